// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Channel Guard

This block models, in synchronous logic, a data channel in which every bit travels on two wires. Each wire pair carries one of four symbols: a spacer, a logic zero, a logic one, or a reserved alarm code. On the sending side, an encoder takes a single-rail word under a valid/ready handshake. It places that word on the dual-rail bus for exactly one cycle and then returns every pair to the spacer. Each data phase therefore raises exactly one wire per bit, whatever the data value is.

On the receiving side, a checker samples the bus on every clock edge and sorts it into one of three classes: all spacer, all logic, or mixed. When a complete word arrives after a spacer, the checker decodes it and presents it as a single-rail word with a one-cycle strobe. The checker raises a sticky alarm when it sees any of these faults: an alarm code on any pair, a bit that jumps directly between logic values, or a word that refills before a full spacer. A watchdog raises a sticky deadlock flag when the bus stays away from the all-spacer state for too long. That covers three cases: a partial word that never completes, a word that drains early, and a complete word that never returns to zero.

The transmit and receive halves of the bus are separate ports. This lets the surrounding logic, or a bench, sit between them and corrupt individual rails.

Top module: `dualrail_guard`

## Requirements
- R1: Pair i of the bus occupies rails [2i+1:2i], and its encoding is 00 for spacer, 01 for logic 0, 10 for logic 1 and 11 for alarm. A word accepted at a clock edge (in_valid high while in_ready is high) appears as its logic pairs on tx_rails right after that edge.
- R2: The encoder has two states, SPACER and TOKEN. in_ready is high only in SPACER. A token stays on tx_rails for exactly one cycle and is always followed by at least one cycle in which every rail is 0.
- R3: While a token is on the bus, exactly WIDTH of the 2*WIDTH transmit rails are high, for every data value.
- R4: The checker samples a complete word (every pair 01 or 10) in state CLEAR or FILL. At the edge where it does so, it drives out_valid high for one cycle after that edge, with out_data bit i equal to rail 2i+1. A complete word that is held does not produce a second strobe.
- R5: A 11 pair in any bit position sets alarm after the edge that samples it. This holds whether that pair was previously spacer or logic.
- R6: A pair that changes directly from 01 to 10, or from 10 to 01, between two consecutive samples sets alarm.
- R7: In state DRAIN, the checker has seen a complete word that is partially back at spacer. If the bus reads complete again in this state, the spacer was skipped and alarm is set.
- R8: The watchdog counts consecutive samples in which the bus is not all spacer. deadlock rises after the WD_LIMIT-th such sample, does not rise after WD_LIMIT-1 of them, and the count restarts whenever an all-spacer sample is seen.
- R9: alarm and deadlock both stay high until a synchronous reset, even after the bus returns to normal. Once either is set, the checker sits in state HALT and never raises out_valid.
- R10: After reset, alarm, deadlock and out_valid are 0, in_ready is 1 and tx_rails is all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | WIDTH | Single-rail word to send |
| in_valid | input | 1 | Sender offers in_data |
| in_ready | output | 1 | Encoder can accept a word this cycle |
| tx_rails | output | 2*WIDTH | Dual-rail bus produced by the encoder |
| rx_rails | input | 2*WIDTH | Dual-rail bus seen by the checker |
| out_data | output | WIDTH | Decoded single-rail word |
| out_valid | output | 1 | One-cycle strobe for out_data |
| alarm | output | 1 | Sticky fault flag |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
Every word of the default width passes through the encoder. For each one, the bench checks the rail pattern, the constant rail weight, the one-cycle token and the decoded strobe. A design that encoded the pair order backwards, or left a token up for two cycles, would fail on the very first words of this sweep.

The bench then drives the receive bus directly to produce each fault in every bit position:
- a spacer pair turning into 11, and a logic pair turning into 11;
- a logic value flipping to the other logic value;
- an early drain followed by a refill.

A checker that looked only at some bit positions, or ignored one of the alarm paths, would leave alarm low in at least one of these cases. For the watchdog, the bench holds a bus that is stuck partial or stuck complete for WD_LIMIT-1 samples and then for WD_LIMIT samples. An off-by-one counter shows up either as an early deadlock or as a missing one. A counter that never restarts shows up as a false deadlock after an intervening spacer. Stickiness is checked by returning the bus to normal traffic after a fault and confirming that no strobe appears and that neither flag drops.

// File: rtl/dualrail_pkg.sv
package dualrail_pkg;

    localparam logic [1:0] PAIR_CLEAR = 2'b00;
    localparam logic [1:0] PAIR_ZERO  = 2'b01;
    localparam logic [1:0] PAIR_ONE   = 2'b10;
    localparam logic [1:0] PAIR_ALARM = 2'b11;

    typedef enum logic {
        TX_SPACER,
        TX_TOKEN
    } tx_state_t;

    typedef enum logic [2:0] {
        CK_CLEAR,
        CK_FILL,
        CK_FULL,
        CK_DRAIN,
        CK_HALT
    } ck_state_t;

    typedef enum logic [1:0] {
        BUS_CLEAR,
        BUS_MIXED,
        BUS_FULL
    } bus_class_t;

    function automatic logic [1:0] pair_of(input logic bit_val);
        return bit_val ? PAIR_ONE : PAIR_ZERO;
    endfunction

endpackage

// File: rtl/dr_encoder.sv
module dr_encoder
    import dualrail_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [2*WIDTH-1:0] tx_rails
);

    tx_state_t        state_q;
    tx_state_t        state_d;
    logic [WIDTH-1:0] data_q;
    logic             token_on;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_SPACER;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: SPACER -accept-> TOKEN, TOKEN -always-> SPACER
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_SPACER: state_d = in_valid ? TX_TOKEN : TX_SPACER;
            TX_TOKEN:  state_d = TX_SPACER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (state_q == TX_SPACER && in_valid) begin
            data_q <= in_data;
        end
    end

    // outputs
    always_comb begin
        in_ready = (state_q == TX_SPACER);
        token_on = (state_q == TX_TOKEN);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign tx_rails[2*i +: 2] = token_on ? pair_of(data_q[i]) : PAIR_CLEAR;
    end

    // R2
    token_then_spacer_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_rails != '0) |=> (tx_rails == '0));

    // R3
    token_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ($countones(tx_rails) == WIDTH));

endmodule

// File: rtl/dr_watchdog.sv
module dr_watchdog #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_C = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!busy) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = busy && (cnt_q == LAST_C);

    // R8
    wd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= LIM_C));

    // R8
    wd_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (cnt_q == '0));

endmodule

// File: rtl/dr_checker.sv
module dr_checker
    import dualrail_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int WD_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] rx_rails,
    output logic [WIDTH-1:0]   out_data,
    output logic               out_valid,
    output logic               alarm,
    output logic               deadlock
);

    ck_state_t          state_q;
    ck_state_t          state_d;
    bus_class_t         cls;
    logic [2*WIDTH-1:0] prev_q;
    logic [WIDTH-1:0]   is_clr;
    logic [WIDTH-1:0]   is_logic;
    logic [WIDTH-1:0]   is_alm;
    logic [WIDTH-1:0]   is_flip;
    logic [WIDTH-1:0]   decoded;
    logic               all_clear;
    logic               all_logic;
    logic               spacer_viol;
    logic               alarm_hit;
    logic               wd_expired;
    logic               take;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] cur;
        logic [1:0] old;
        assign cur         = rx_rails[2*i +: 2];
        assign old         = prev_q[2*i +: 2];
        assign is_clr[i]   = (cur == PAIR_CLEAR);
        assign is_alm[i]   = (cur == PAIR_ALARM);
        assign is_logic[i] = (cur == PAIR_ZERO) || (cur == PAIR_ONE);
        assign is_flip[i]  = ((old == PAIR_ZERO) && (cur == PAIR_ONE)) ||
                             ((old == PAIR_ONE)  && (cur == PAIR_ZERO));
        assign decoded[i]  = cur[1];
    end

    always_comb begin
        all_clear   = &is_clr;
        all_logic   = &is_logic;
        if (all_clear) begin
            cls = BUS_CLEAR;
        end else if (all_logic) begin
            cls = BUS_FULL;
        end else begin
            cls = BUS_MIXED;
        end
        spacer_viol = (state_q == CK_DRAIN) && all_logic;
        alarm_hit   = (|is_alm) || (|is_flip) || spacer_viol;
        take        = all_logic && !alarm_hit && !wd_expired &&
                      ((state_q == CK_CLEAR) || (state_q == CK_FILL));
    end

    dr_watchdog #(
        .LIMIT(WD_LIMIT)
    ) u_wd (
        .clk    (clk),
        .rst    (rst),
        .busy   (!all_clear),
        .expired(wd_expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CK_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (alarm_hit || wd_expired) begin
            state_d = CK_HALT;
        end else begin
            unique case (state_q)
                CK_CLEAR, CK_FILL: begin
                    unique case (cls)
                        BUS_CLEAR: state_d = CK_CLEAR;
                        BUS_MIXED: state_d = CK_FILL;
                        BUS_FULL:  state_d = CK_FULL;
                        default:   state_d = CK_HALT;
                    endcase
                end
                CK_FULL, CK_DRAIN: begin
                    unique case (cls)
                        BUS_CLEAR: state_d = CK_CLEAR;
                        BUS_MIXED: state_d = CK_DRAIN;
                        BUS_FULL:  state_d = state_q;
                        default:   state_d = CK_HALT;
                    endcase
                end
                CK_HALT: state_d = CK_HALT;
                default: state_d = CK_HALT;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            alarm     <= 1'b0;
            deadlock  <= 1'b0;
        end else begin
            prev_q    <= rx_rails;
            out_valid <= take;
            alarm     <= alarm | alarm_hit;
            deadlock  <= deadlock | wd_expired;
            if (take) begin
                out_data <= decoded;
            end
        end
    end

    // R5
    pair_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (|is_alm) |=> alarm);

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        alarm |=> alarm);

    // R9
    deadlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm || deadlock) |-> !out_valid);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/dualrail_guard.sv
module dualrail_guard #(
    parameter int WIDTH    = 8,
    parameter int WD_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [2*WIDTH-1:0] tx_rails,
    input  logic [2*WIDTH-1:0] rx_rails,
    output logic [WIDTH-1:0]   out_data,
    output logic               out_valid,
    output logic               alarm,
    output logic               deadlock
);

    dr_encoder #(
        .WIDTH(WIDTH)
    ) u_enc (
        .clk     (clk),
        .rst     (rst),
        .in_data (in_data),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .tx_rails(tx_rails)
    );

    dr_checker #(
        .WIDTH   (WIDTH),
        .WD_LIMIT(WD_LIMIT)
    ) u_chk (
        .clk      (clk),
        .rst      (rst),
        .rx_rails (rx_rails),
        .out_data (out_data),
        .out_valid(out_valid),
        .alarm    (alarm),
        .deadlock (deadlock)
    );

endmodule

// File: tb/dualrail_guard_bench.sv
`timescale 1ns/1ps
module dualrail_guard_bench;

    localparam int W = 8;
    localparam int L = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   in_data = '0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [2*W-1:0] tx_rails;
    logic [2*W-1:0] rx_rails;
    logic [W-1:0]   out_data;
    logic           out_valid;
    logic           alarm;
    logic           deadlock;
    logic           force_en = 1'b0;
    logic [2*W-1:0] force_val = '0;

    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    assign rx_rails = force_en ? force_val : tx_rails;

    dualrail_guard #(
        .WIDTH   (W),
        .WD_LIMIT(L)
    ) u_dualrail_guard (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .tx_rails (tx_rails),
        .rx_rails (rx_rails),
        .out_data (out_data),
        .out_valid(out_valid),
        .alarm    (alarm),
        .deadlock (deadlock)
    );

    function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
        end
        return r;
    endfunction

    function automatic logic [2*W-1:0] set_pair(input logic [2*W-1:0] v,
                                                input int j, input logic [1:0] p);
        logic [2*W-1:0] r;
        r = v;
        r[2*j +: 2] = p;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        force_en = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst       = 1'b0;
        force_en  = 1'b1;
        force_val = '0;
    endtask

    task automatic apply(input logic [2*W-1:0] v);
        force_val = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [W-1:0]   w;
        logic [2*W-1:0] part;

        // R10 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(alarm == 1'b0,     "R10 alarm",     alarm, 0);
        chk(deadlock == 1'b0,  "R10 deadlock",  deadlock, 0);
        chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        chk(in_ready == 1'b1,  "R10 in_ready",  in_ready, 1);
        chk(tx_rails == '0,    "R10 tx_rails",  tx_rails, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4: every word through the encoder
        for (int v = 0; v < (1 << W); v++) begin
            w        = W'(v);
            in_data  = w;
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            chk(tx_rails == enc(w), "R1 token rails", tx_rails, enc(w));
            chk($countones(tx_rails) == W, "R3 rail weight",
                $countones(tx_rails), W);
            chk(in_ready == 1'b0, "R2 ready low in token", in_ready, 0);
            chk(out_valid == 1'b0, "R4 no early strobe", out_valid, 0);
            @(posedge clk);
            @(negedge clk);
            chk(tx_rails == '0, "R2 spacer after token", tx_rails, 0);
            chk(out_valid == 1'b1, "R4 strobe", out_valid, 1);
            chk(out_data == w, "R4 decoded data", out_data, w);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 strobe ends", out_valid, 0);
        chk(alarm == 1'b0, "R5 no false alarm", alarm, 0);
        chk(deadlock == 1'b0, "R8 no false deadlock", deadlock, 0);

        // R5 spacer pair becomes 11
        for (int j = 0; j < W; j++) begin
            do_reset();
            apply('0);
            chk(alarm == 1'b0, "R5 quiet before", alarm, 0);
            apply(set_pair('0, j, 2'b11));
            chk(alarm == 1'b1, "R5 clear->11", alarm, 1);
            chk(deadlock == 1'b0, "R5 no deadlock", deadlock, 0);
        end

        // R5 logic pair becomes 11
        for (int j = 0; j < W; j++) begin
            do_reset();
            apply(enc(8'hA5));
            chk(out_valid == 1'b1 && alarm == 1'b0, "R4 forced token",
                {out_valid, alarm}, 2'b10);
            apply(set_pair(enc(8'hA5), j, 2'b11));
            chk(alarm == 1'b1, "R5 logic->11", alarm, 1);
        end

        // R6 direct logic flip, with a spaced control
        for (int j = 0; j < W; j++) begin
            w = 8'h3C;
            do_reset();
            apply(enc(w));
            apply('0);
            apply(enc(w ^ W'(1 << j)));
            chk(alarm == 1'b0, "R6 spaced change ok", alarm, 0);
            chk(out_valid == 1'b1 && out_data == (w ^ W'(1 << j)),
                "R4 second token", out_data, w ^ W'(1 << j));
            do_reset();
            apply(enc(w));
            apply(enc(w ^ W'(1 << j)));
            chk(alarm == 1'b1, "R6 direct flip", alarm, 1);
            chk(out_valid == 1'b0, "R9 no strobe on flip", out_valid, 0);
        end

        // R7 refill without full spacer
        for (int j = 0; j < W; j++) begin
            do_reset();
            apply(enc(8'h96));
            apply(set_pair(enc(8'h96), j, 2'b00));
            chk(alarm == 1'b0, "R7 drain ok", alarm, 0);
            apply(enc(8'h96));
            chk(alarm == 1'b1, "R7 refill", alarm, 1);
        end

        // R8 early fall: token then partial
        do_reset();
        part = set_pair(enc(8'h5A), 3, 2'b00);
        apply(enc(8'h5A));
        for (int k = 0; k < L - 2; k++) apply(part);
        chk(deadlock == 1'b0, "R8 early fall below limit", deadlock, 0);
        apply(part);
        chk(deadlock == 1'b1, "R8 early fall at limit", deadlock, 1);
        chk(alarm == 1'b0, "R8 no alarm", alarm, 0);

        // R8 logic out of turn from spacer, with restart
        for (int j = 0; j < W; j++) begin
            do_reset();
            part = set_pair('0, j, 2'b10);
            for (int k = 0; k < L - 1; k++) apply(part);
            apply('0);
            for (int k = 0; k < L - 1; k++) apply(part);
            chk(deadlock == 1'b0, "R8 restart on spacer", deadlock, 0);
            apply(part);
            chk(deadlock == 1'b1, "R8 stuck partial", deadlock, 1);
        end

        // R8 R4 stuck complete word
        do_reset();
        apply(enc(8'hC3));
        chk(out_valid == 1'b1, "R4 held word strobe", out_valid, 1);
        apply(enc(8'hC3));
        chk(out_valid == 1'b0, "R4 held word single", out_valid, 0);
        for (int k = 0; k < L - 3; k++) apply(enc(8'hC3));
        chk(deadlock == 1'b0, "R8 stuck full below limit", deadlock, 0);
        apply(enc(8'hC3));
        chk(deadlock == 1'b1, "R8 stuck full at limit", deadlock, 1);

        // R9 stickiness of deadlock with clean bus afterwards
        apply('0);
        apply(enc(8'h11));
        chk(deadlock == 1'b1, "R9 deadlock sticky", deadlock, 1);
        chk(out_valid == 1'b0, "R9 no strobe after deadlock", out_valid, 0);

        // R9 stickiness of alarm with encoder traffic afterwards
        do_reset();
        apply(set_pair('0, 5, 2'b11));
        force_en = 1'b0;
        in_data  = 8'h77;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no strobe after alarm", out_valid, 0);
        chk(alarm == 1'b1, "R9 alarm sticky", alarm, 1);
        do_reset();
        chk(alarm == 1'b0 && deadlock == 1'b0, "R9 reset releases",
            {alarm, deadlock}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule